// File: doc/BRIEF.md
# Linear CCD line timing generator

This block produces the digital drive pattern for one line of a dual-output linear CCD, counted entirely in cycles of a single fast system clock. A line begins when `line_start` is pulsed while the block is idle and the programmed settings pass an admission check. The block then runs a fixed sequence. A guard interval comes first. The transfer gate pulse follows, then a second guard interval. After that the shift register is clocked: first the prescan cells, then the useful pixels, then any postscan cells the caller asked for. The two register phases are driven in antiphase. A short reset pulse sits at the start of every high half of the second register phase. An optional shutter pulse on the antiblooming phase ends a programmable number of cycles into the readout, which shortens the exposure that ends at the next transfer.

A downstream ADC capture stage takes video on `pix_valid`, a one-cycle strobe that fires on each falling edge of the second register phase that carries a useful pixel. `pix_idx` gives that pixel's number. All five phases and the strobe leave the block from one output register stage, so they stay aligned cycle for cycle.

The state machine has six states. `ST_IDLE` waits for a trigger. `ST_PRE_GUARD` holds the register phases still before the transfer. `ST_XFER` drives the transfer gate. `ST_POST_GUARD` holds the phases still after it. `ST_SHIFT_HI` is the half pixel with the second phase high and `ST_SHIFT_LO` is the half with it low. The transitions are as follows. Idle→pre-guard on an admitted trigger. Pre-guard→transfer after `guard_len` cycles. Transfer→post-guard after `xfer_len` cycles. Post-guard→shift-high after `guard_len` cycles. Shift-high→shift-low after `half_len` cycles. Shift-low→shift-high after `half_len` cycles while shifts remain. Shift-low→idle after the last shift.

Top module: `ccd_line_timer`

## Requirements
- R1: After reset, phi_l1 is 1, every other phase output is 0, and pix_valid, pix_idx, busy, cfg_err and overrun_cnt are all 0.
- R2: When line_start is sampled high in idle with legal settings, busy rises on the second rising edge after that sample. For guard_len cycles before the transfer pulse and guard_len cycles after it, phi_l1 stays 1 and phi_l2 stays 0.
- R3: phi_p is high for exactly xfer_len consecutive cycles, starting guard_len cycles after busy rises. The register phases do not move while it is high.
- R4: Each shift lasts 2*half_len cycles. phi_l2 is 1 for the first half_len cycles and 0 for the rest, and phi_l1 is always the inverse of phi_l2.
- R5: phi_r is 1 for the first rst_len cycles of each shift and low before phi_l2 falls. During the guard and transfer intervals phi_r equals reset_hold (1 holds it high, 0 keeps it low).
- R6: A line clocks 4 prescan shifts, then the useful pixels (512 when long_sel is 0, 1024 when it is 1), then post_cnt postscan shifts. Busy falls in the cycle right after the last shift ends.
- R7: pix_valid is a one-cycle strobe on the cycle in which phi_l2 falls, only for shifts 5 through 4+useful (the first useful pixel is on the fifth falling edge after the transfer pulse).
- R8: pix_idx is 0 when busy rises. With each pix_valid strobe it takes that pixel's number, counting from 0. It holds its value at all other times, including during prescan, postscan and idle.
- R9: With shut_en at 1, phi_a is high for exactly shut_len cycles, starting shut_delay cycles after the first shift cycle. With shut_en at 0, phi_a stays low.
- R10: A trigger is refused, busy stays low and cfg_err is set if any of these holds: xfer_len < 30, guard_len < 1, half_len < 2, rst_len is 0 or rst_len >= half_len, or (with shut_en) shut_len < 20 or shut_delay+shut_len+10 exceeds the readout length in cycles. An admitted trigger clears cfg_err.
- R11: A trigger while a line is running does not change the waveform. Each one increments overrun_cnt by one, and the counter holds at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Line trigger |
| long_sel | input | 1 | 0: 512 useful pixels, 1: 1024 |
| reset_hold | input | 1 | Hold phi_r high through the transfer period |
| shut_en | input | 1 | Enable the shutter pulse |
| guard_len | input | 8 | Guard interval on each side of the transfer pulse, cycles |
| xfer_len | input | 8 | Transfer pulse width, cycles |
| half_len | input | 8 | Half a pixel period, cycles |
| rst_len | input | 8 | Reset pulse width, cycles |
| post_cnt | input | 8 | Number of postscan shifts |
| shut_delay | input | 16 | Shutter start, cycles after readout begins |
| shut_len | input | 16 | Shutter pulse width, cycles |
| phi_p | output | 1 | Transfer gate phase |
| phi_l1 | output | 1 | First register phase |
| phi_l2 | output | 1 | Second register phase |
| phi_r | output | 1 | Reset phase |
| phi_a | output | 1 | Antiblooming shutter phase |
| pix_valid | output | 1 | Useful pixel strobe |
| pix_idx | output | 10 | Useful pixel number |
| busy | output | 1 | Line in progress |
| cfg_err | output | 1 | Last trigger refused |
| overrun_cnt | output | 8 | Triggers ignored during a line |

## Verification
Every admitted line is compared cycle by cycle against a waveform the bench derives from the settings alone. This means a wrong guard, transfer width, half period, reset width or shift count shows up as a misplaced edge on a named phase. Directed lines cover the smallest legal timings, a long sensor with postscan, reset hold and mid-line triggers, and a shutter whose end sits exactly at the feasibility limit. Random short lines vary every timing field, the reset mode and the shutter placement together, which separates faults in one counter from faults in another. Refused settings are each tried one step past a limit, with the matching in-limit value admitted elsewhere.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_GUARD,
        ST_XFER,
        ST_POST_GUARD,
        ST_SHIFT_HI,
        ST_SHIFT_LO
    } seq_state_e;

    function automatic logic is_shifting(seq_state_e s);
        return (s == ST_SHIFT_HI) || (s == ST_SHIFT_LO);
    endfunction

endpackage

// File: rtl/ccd_cfg_check.sv
module ccd_cfg_check #(
    parameter int TW        = 8,
    parameter int PW        = 8,
    parameter int EW        = 16,
    parameter int KW        = 11,
    parameter int PRESCAN   = 4,
    parameter int SHORT_PIX = 512,
    parameter int LONG_PIX  = 1024,
    parameter int MIN_XFER  = 30,
    parameter int MIN_GUARD = 1,
    parameter int MIN_HALF  = 2,
    parameter int MIN_SHUT  = 20,
    parameter int MIN_GAP   = 10
) (
    input  logic          long_sel,
    input  logic          shut_en,
    input  logic [TW-1:0] guard_len,
    input  logic [TW-1:0] xfer_len,
    input  logic [TW-1:0] half_len,
    input  logic [TW-1:0] rst_len,
    input  logic [PW-1:0] post_cnt,
    input  logic [EW-1:0] shut_delay,
    input  logic [EW-1:0] shut_len,
    output logic [KW-1:0] shifts_total,
    output logic          cfg_ok
);
    localparam int RW = KW + TW + 1;
    localparam int SW = EW + 2;
    localparam int CW = ((RW > SW) ? RW : SW) + 1;

    logic [CW-1:0] readout_cyc;
    logic [CW-1:0] shut_end;
    logic          time_ok;
    logic          shut_ok;

    always_comb begin
        shifts_total = KW'(PRESCAN)
                     + (long_sel ? KW'(LONG_PIX) : KW'(SHORT_PIX))
                     + KW'(post_cnt);
        readout_cyc  = CW'(shifts_total) * CW'({half_len, 1'b0});
        shut_end     = CW'(shut_delay) + CW'(shut_len) + CW'(MIN_GAP);
        time_ok      = (xfer_len  >= TW'(MIN_XFER))
                    && (guard_len >= TW'(MIN_GUARD))
                    && (half_len  >= TW'(MIN_HALF))
                    && (rst_len   != '0)
                    && (rst_len   <  half_len);
        shut_ok      = !shut_en
                    || ((shut_len >= EW'(MIN_SHUT)) && (shut_end <= readout_cyc));
        cfg_ok       = time_ok && shut_ok;
    end

endmodule

// File: rtl/ccd_seq_fsm.sv
module ccd_seq_fsm
    import ccd_seq_pkg::*;
#(
    parameter int TW        = 8,
    parameter int EW        = 16,
    parameter int KW        = 11,
    parameter int UW        = 11,
    parameter int RW        = 20,
    parameter int OW        = 8,
    parameter int SHORT_PIX = 512,
    parameter int LONG_PIX  = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          cfg_ok,
    input  logic [KW-1:0] shifts_total,
    input  logic          long_sel,
    input  logic          reset_hold,
    input  logic          shut_en,
    input  logic [TW-1:0] guard_len,
    input  logic [TW-1:0] xfer_len,
    input  logic [TW-1:0] half_len,
    input  logic [TW-1:0] rst_len,
    input  logic [EW-1:0] shut_delay,
    input  logic [EW-1:0] shut_len,
    output seq_state_e    state,
    output logic [TW-1:0] ph_cnt,
    output logic [KW-1:0] shift_k,
    output logic [RW-1:0] shut_tm,
    output logic [TW-1:0] rl_q,
    output logic          hold_q,
    output logic          shen_q,
    output logic [EW-1:0] d_q,
    output logic [EW-1:0] len_q,
    output logic [UW-1:0] useful_q,
    output logic          cfg_err,
    output logic [OW-1:0] overrun_cnt
);
    seq_state_e    state_nx;
    logic [TW-1:0] ph_nx;
    logic [KW-1:0] k_nx;
    logic [RW-1:0] tm_nx;
    logic [TW-1:0] g_q, x_q, h_q;
    logic [KW-1:0] n_q;
    logic          accept, refuse, ignore;

    assign accept = (state == ST_IDLE) && line_start && cfg_ok;
    assign refuse = (state == ST_IDLE) && line_start && !cfg_ok;
    assign ignore = (state != ST_IDLE) && line_start;

    always_comb begin
        state_nx = state;
        ph_nx    = ph_cnt + TW'(1);
        k_nx     = shift_k;
        tm_nx    = shut_tm;
        if (is_shifting(state) && (shut_tm != '1)) begin
            tm_nx = shut_tm + RW'(1);
        end
        unique case (state)
            ST_IDLE: begin
                ph_nx = '0;
                if (accept) begin
                    state_nx = ST_PRE_GUARD;
                end
            end
            ST_PRE_GUARD: begin
                if (ph_cnt == g_q - TW'(1)) begin
                    state_nx = ST_XFER;
                    ph_nx    = '0;
                end
            end
            ST_XFER: begin
                if (ph_cnt == x_q - TW'(1)) begin
                    state_nx = ST_POST_GUARD;
                    ph_nx    = '0;
                end
            end
            ST_POST_GUARD: begin
                if (ph_cnt == g_q - TW'(1)) begin
                    state_nx = ST_SHIFT_HI;
                    ph_nx    = '0;
                    k_nx     = '0;
                    tm_nx    = '0;
                end
            end
            ST_SHIFT_HI: begin
                if (ph_cnt == h_q - TW'(1)) begin
                    state_nx = ST_SHIFT_LO;
                    ph_nx    = '0;
                end
            end
            ST_SHIFT_LO: begin
                if (ph_cnt == h_q - TW'(1)) begin
                    ph_nx = '0;
                    if (shift_k == n_q - KW'(1)) begin
                        state_nx = ST_IDLE;
                    end else begin
                        state_nx = ST_SHIFT_HI;
                        k_nx     = shift_k + KW'(1);
                    end
                end
            end
            default: begin
                state_nx = ST_IDLE;
                ph_nx    = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            ph_cnt      <= '0;
            shift_k     <= '0;
            shut_tm     <= '0;
            g_q         <= '0;
            x_q         <= '0;
            h_q         <= '0;
            n_q         <= '0;
            rl_q        <= '0;
            hold_q      <= 1'b0;
            shen_q      <= 1'b0;
            d_q         <= '0;
            len_q       <= '0;
            useful_q    <= '0;
            cfg_err     <= 1'b0;
            overrun_cnt <= '0;
        end else begin
            state   <= state_nx;
            ph_cnt  <= ph_nx;
            shift_k <= k_nx;
            shut_tm <= tm_nx;
            if (accept) begin
                g_q      <= guard_len;
                x_q      <= xfer_len;
                h_q      <= half_len;
                n_q      <= shifts_total;
                rl_q     <= rst_len;
                hold_q   <= reset_hold;
                shen_q   <= shut_en;
                d_q      <= shut_delay;
                len_q    <= shut_len;
                useful_q <= long_sel ? UW'(LONG_PIX) : UW'(SHORT_PIX);
                cfg_err  <= 1'b0;
            end else if (refuse) begin
                cfg_err  <= 1'b1;
            end
            if (ignore && (overrun_cnt != '1)) begin
                overrun_cnt <= overrun_cnt + OW'(1);
            end
        end
    end

endmodule

// File: rtl/ccd_phase_out.sv
module ccd_phase_out
    import ccd_seq_pkg::*;
#(
    parameter int TW      = 8,
    parameter int EW      = 16,
    parameter int KW      = 11,
    parameter int UW      = 11,
    parameter int IW      = 10,
    parameter int RW      = 20,
    parameter int PRESCAN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_state_e    state,
    input  logic [TW-1:0] ph_cnt,
    input  logic [KW-1:0] shift_k,
    input  logic [RW-1:0] shut_tm,
    input  logic [TW-1:0] rl_q,
    input  logic          hold_q,
    input  logic          shen_q,
    input  logic [EW-1:0] d_q,
    input  logic [EW-1:0] len_q,
    input  logic [UW-1:0] useful_q,
    output logic          phi_p,
    output logic          phi_l1,
    output logic          phi_l2,
    output logic          phi_r,
    output logic          phi_a,
    output logic          pix_valid,
    output logic [IW-1:0] pix_idx,
    output logic          busy
);
    localparam int CW = ((RW > EW + 1) ? RW : EW + 1) + 1;

    logic          p_d, l2_d, r_d, a_d, v_d;
    logic          useful_shift;
    logic [CW-1:0] tm_x, a_lo, a_hi;

    always_comb begin
        useful_shift = (shift_k >= KW'(PRESCAN))
                    && (shift_k <  KW'(PRESCAN) + KW'(useful_q));
        tm_x = CW'(shut_tm);
        a_lo = CW'(d_q);
        a_hi = CW'(d_q) + CW'(len_q);
        p_d  = 1'b0;
        l2_d = 1'b0;
        r_d  = 1'b0;
        v_d  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                r_d = 1'b0;
            end
            ST_PRE_GUARD, ST_POST_GUARD: begin
                r_d = hold_q;
            end
            ST_XFER: begin
                p_d = 1'b1;
                r_d = hold_q;
            end
            ST_SHIFT_HI: begin
                l2_d = 1'b1;
                r_d  = (ph_cnt < rl_q);
            end
            ST_SHIFT_LO: begin
                v_d = (ph_cnt == '0) && useful_shift;
            end
            default: begin
                r_d = 1'b0;
            end
        endcase
        a_d = shen_q && is_shifting(state) && (tm_x >= a_lo) && (tm_x < a_hi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phi_p     <= 1'b0;
            phi_l1    <= 1'b1;
            phi_l2    <= 1'b0;
            phi_r     <= 1'b0;
            phi_a     <= 1'b0;
            pix_valid <= 1'b0;
            pix_idx   <= '0;
            busy      <= 1'b0;
        end else begin
            phi_p     <= p_d;
            phi_l1    <= !l2_d;
            phi_l2    <= l2_d;
            phi_r     <= r_d;
            phi_a     <= a_d;
            pix_valid <= v_d;
            busy      <= (state != ST_IDLE);
            if ((state == ST_PRE_GUARD) && (ph_cnt == '0)) begin
                pix_idx <= '0;
            end else if (v_d) begin
                pix_idx <= IW'(shift_k - KW'(PRESCAN));
            end
        end
    end

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
    import ccd_seq_pkg::*;
#(
    parameter int TW        = 8,
    parameter int PW        = 8,
    parameter int EW        = 16,
    parameter int OW        = 8,
    parameter int PRESCAN   = 4,
    parameter int SHORT_PIX = 512,
    parameter int LONG_PIX  = 1024,
    parameter int MIN_XFER  = 30,
    parameter int MIN_GUARD = 1,
    parameter int MIN_HALF  = 2,
    parameter int MIN_SHUT  = 20,
    parameter int MIN_GAP   = 10,
    localparam int KW = $clog2(PRESCAN + LONG_PIX + (1 << PW)),
    localparam int UW = $clog2(LONG_PIX + 1),
    localparam int IW = $clog2(LONG_PIX),
    localparam int RW = KW + TW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          long_sel,
    input  logic          reset_hold,
    input  logic          shut_en,
    input  logic [TW-1:0] guard_len,
    input  logic [TW-1:0] xfer_len,
    input  logic [TW-1:0] half_len,
    input  logic [TW-1:0] rst_len,
    input  logic [PW-1:0] post_cnt,
    input  logic [EW-1:0] shut_delay,
    input  logic [EW-1:0] shut_len,
    output logic          phi_p,
    output logic          phi_l1,
    output logic          phi_l2,
    output logic          phi_r,
    output logic          phi_a,
    output logic          pix_valid,
    output logic [IW-1:0] pix_idx,
    output logic          busy,
    output logic          cfg_err,
    output logic [OW-1:0] overrun_cnt
);
    logic [KW-1:0] shifts_total;
    logic          cfg_ok;
    seq_state_e    state;
    logic [TW-1:0] ph_cnt;
    logic [KW-1:0] shift_k;
    logic [RW-1:0] shut_tm;
    logic [TW-1:0] rl_q;
    logic          hold_q, shen_q;
    logic [EW-1:0] d_q, len_q;
    logic [UW-1:0] useful_q;

    ccd_cfg_check #(
        .TW(TW), .PW(PW), .EW(EW), .KW(KW), .PRESCAN(PRESCAN),
        .SHORT_PIX(SHORT_PIX), .LONG_PIX(LONG_PIX), .MIN_XFER(MIN_XFER),
        .MIN_GUARD(MIN_GUARD), .MIN_HALF(MIN_HALF), .MIN_SHUT(MIN_SHUT),
        .MIN_GAP(MIN_GAP)
    ) u_check (
        .long_sel(long_sel), .shut_en(shut_en), .guard_len(guard_len),
        .xfer_len(xfer_len), .half_len(half_len), .rst_len(rst_len),
        .post_cnt(post_cnt), .shut_delay(shut_delay), .shut_len(shut_len),
        .shifts_total(shifts_total), .cfg_ok(cfg_ok)
    );

    ccd_seq_fsm #(
        .TW(TW), .EW(EW), .KW(KW), .UW(UW), .RW(RW), .OW(OW),
        .SHORT_PIX(SHORT_PIX), .LONG_PIX(LONG_PIX)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .cfg_ok(cfg_ok),
        .shifts_total(shifts_total), .long_sel(long_sel),
        .reset_hold(reset_hold), .shut_en(shut_en), .guard_len(guard_len),
        .xfer_len(xfer_len), .half_len(half_len), .rst_len(rst_len),
        .shut_delay(shut_delay), .shut_len(shut_len), .state(state),
        .ph_cnt(ph_cnt), .shift_k(shift_k), .shut_tm(shut_tm), .rl_q(rl_q),
        .hold_q(hold_q), .shen_q(shen_q), .d_q(d_q), .len_q(len_q),
        .useful_q(useful_q), .cfg_err(cfg_err), .overrun_cnt(overrun_cnt)
    );

    ccd_phase_out #(
        .TW(TW), .EW(EW), .KW(KW), .UW(UW), .IW(IW), .RW(RW),
        .PRESCAN(PRESCAN)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .state(state), .ph_cnt(ph_cnt),
        .shift_k(shift_k), .shut_tm(shut_tm), .rl_q(rl_q), .hold_q(hold_q),
        .shen_q(shen_q), .d_q(d_q), .len_q(len_q), .useful_q(useful_q),
        .phi_p(phi_p), .phi_l1(phi_l1), .phi_l2(phi_l2), .phi_r(phi_r),
        .phi_a(phi_a), .pix_valid(pix_valid), .pix_idx(pix_idx), .busy(busy)
    );

endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk #(
    parameter int MIN_XFER = 30,
    parameter int OW       = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          phi_p,
    input logic          phi_l1,
    input logic          phi_l2,
    input logic          phi_r,
    input logic          phi_a,
    input logic          pix_valid,
    input logic          busy,
    input logic [OW-1:0] overrun_cnt
);
    logic [15:0] p_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_run <= '0;
        end else if (phi_p) begin
            if (p_run != '1) p_run <= p_run + 16'd1;
        end else begin
            p_run <= '0;
        end
    end

    assert_xfer_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phi_p) |-> (32'(p_run) >= MIN_XFER));

    assert_frozen_phases_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phi_p |-> ($stable(phi_l1) && $stable(phi_l2)));

    assert_antiphase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phi_l1 != phi_l2);

    assert_reset_before_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phi_l2) |-> !$past(phi_r));

    assert_valid_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $fell(phi_l2));

    assert_quiet_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!phi_p && !phi_a && !pix_valid));

    assert_overrun_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_cnt != $past(overrun_cnt)) |-> (overrun_cnt == $past(overrun_cnt) + OW'(1)));

endmodule

bind ccd_line_timer ccd_line_timer_chk #(
    .MIN_XFER(MIN_XFER),
    .OW(OW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .phi_p(phi_p), .phi_l1(phi_l1),
    .phi_l2(phi_l2), .phi_r(phi_r), .phi_a(phi_a), .pix_valid(pix_valid),
    .busy(busy), .overrun_cnt(overrun_cnt)
);

// File: tb/sim_ccd_line_timer.sv
module sim_ccd_line_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic        long_sel = 1'b0;
    logic        reset_hold = 1'b0;
    logic        shut_en = 1'b0;
    logic [7:0]  guard_len = 8'd1;
    logic [7:0]  xfer_len = 8'd30;
    logic [7:0]  half_len = 8'd2;
    logic [7:0]  rst_len = 8'd1;
    logic [7:0]  post_cnt = 8'd0;
    logic [15:0] shut_delay = 16'd0;
    logic [15:0] shut_len = 16'd0;
    logic        phi_p, phi_l1, phi_l2, phi_r, phi_a, pix_valid, busy, cfg_err;
    logic [9:0]  pix_idx;
    logic [7:0]  overrun_cnt;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    ccd_line_timer u0 (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .long_sel(long_sel),
        .reset_hold(reset_hold), .shut_en(shut_en), .guard_len(guard_len),
        .xfer_len(xfer_len), .half_len(half_len), .rst_len(rst_len),
        .post_cnt(post_cnt), .shut_delay(shut_delay), .shut_len(shut_len),
        .phi_p(phi_p), .phi_l1(phi_l1), .phi_l2(phi_l2), .phi_r(phi_r),
        .phi_a(phi_a), .pix_valid(pix_valid), .pix_idx(pix_idx), .busy(busy),
        .cfg_err(cfg_err), .overrun_cnt(overrun_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report_and_end();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic apply(input int g, x, h, rl, post, input bit lng, hold, sh,
                         input int d, len);
        guard_len  = 8'(g);
        xfer_len   = 8'(x);
        half_len   = 8'(h);
        rst_len    = 8'(rl);
        post_cnt   = 8'(post);
        long_sel   = lng;
        reset_hold = hold;
        shut_en    = sh;
        shut_delay = 16'(d);
        shut_len   = 16'(len);
    endtask

    // Runs one admitted line and compares every output cycle against the model.
    task automatic run_line(input int g, x, h, rl, post, input bit lng, hold, sh,
                            input int d, len, nov);
        int u, n, s, e, base_ov, idx_m, k, o, sft;
        int ft[8];
        int av[8];
        int ev[8];
        int ex[8];
        int ac[8];
        string nm[8];
        bit l2e;
        u = lng ? 1024 : 512;
        n = 4 + u + post;
        s = 2 * g + x;
        e = s + n * 2 * h;
        nm = '{"R6 busy", "R3 phi_p", "R4 phi_l1", "R4 phi_l2",
               "R5 phi_r", "R9 phi_a", "R7 pix_valid", "R8 pix_idx"};
        foreach (ft[i]) begin
            ft[i] = -1;
            av[i] = 0;
            ev[i] = 0;
        end
        @(negedge clk);
        apply(g, x, h, rl, post, lng, hold, sh, d, len);
        base_ov = int'(overrun_cnt);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        check(busy == 1'b0, "R2 busy one cycle after trigger", int'(busy), 0);
        @(negedge clk);
        check(busy == 1'b1, "R2 busy two cycles after trigger", int'(busy), 1);
        idx_m = 0;
        k = 0;
        for (int t = 0; t <= e; t++) begin
            if (t > 0) @(negedge clk);
            ex[0] = (t < e) ? 1 : 0;
            ex[1] = 0;
            l2e = 1'b0;
            ex[4] = 0;
            ex[5] = 0;
            ex[6] = 0;
            if (t < s) begin
                ex[4] = hold ? 1 : 0;
                ex[1] = (t >= g && t < g + x) ? 1 : 0;
            end else if (t < e) begin
                sft = t - s;
                k = sft / (2 * h);
                o = sft % (2 * h);
                l2e = (o < h);
                ex[4] = (o < rl) ? 1 : 0;
                ex[6] = (o == h && k >= 4 && k < 4 + u) ? 1 : 0;
                ex[5] = (sh && sft >= d && sft < d + len) ? 1 : 0;
            end
            if (ex[6] == 1) idx_m = k - 4;
            ex[2] = l2e ? 0 : 1;
            ex[3] = l2e ? 1 : 0;
            ex[7] = idx_m;
            ac = '{int'(busy), int'(phi_p), int'(phi_l1), int'(phi_l2),
                   int'(phi_r), int'(phi_a), int'(pix_valid), int'(pix_idx)};
            for (int i = 0; i < 8; i++) begin
                if (ac[i] != ex[i] && ft[i] < 0) begin
                    ft[i] = t;
                    av[i] = ac[i];
                    ev[i] = ex[i];
                end
            end
            // R11: extra triggers while the line runs
            line_start = (nov > 0 && t >= s + 5 && t < s + 5 + 2 * nov
                          && ((t - s - 5) % 2 == 0));
        end
        line_start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            check(ft[i] < 0, $sformatf("%s trace at t=%0d", nm[i], ft[i]), av[i], ev[i]);
        end
        check(int'(overrun_cnt) == base_ov + nov, "R11 overrun count",
              int'(overrun_cnt), base_ov + nov);
        check(cfg_err == 1'b0, "R10 admitted trigger clears cfg_err", int'(cfg_err), 0);
    endtask

    task automatic try_refuse(input string req, input int g, x, h, rl, post,
                              input bit lng, sh, input int d, len);
        int seen;
        seen = 0;
        @(negedge clk);
        apply(g, x, h, rl, post, lng, 1'b0, sh, d, len);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        check(seen == 0, {req, " busy stays low"}, seen, 0);
        check(cfg_err == 1'b1, {req, " cfg_err set"}, int'(cfg_err), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        report_and_end();
    end

    initial begin
        int g, x, h, rl, post, len, d, rd, seed_v;
        bit hold, sh;
        seed_v = int'($urandom(32'd7011));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(phi_l1 == 1'b1, "R1 phi_l1 after reset", int'(phi_l1), 1);
        check(phi_l2 == 1'b0, "R1 phi_l2 after reset", int'(phi_l2), 0);
        check(phi_p == 1'b0, "R1 phi_p after reset", int'(phi_p), 0);
        check(phi_r == 1'b0, "R1 phi_r after reset", int'(phi_r), 0);
        check(phi_a == 1'b0, "R1 phi_a after reset", int'(phi_a), 0);
        check(pix_valid == 1'b0, "R1 pix_valid after reset", int'(pix_valid), 0);
        check(pix_idx == 10'd0, "R1 pix_idx after reset", int'(pix_idx), 0);
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(cfg_err == 1'b0, "R1 cfg_err after reset", int'(cfg_err), 0);
        check(overrun_cnt == 8'd0, "R1 overrun after reset", int'(overrun_cnt), 0);

        // smallest legal timings, short sensor
        run_line(1, 30, 2, 1, 0, 1'b0, 1'b0, 1'b0, 0, 0, 0);
        // long sensor, postscan, reset hold, shutter, three ignored triggers
        run_line(3, 70, 3, 2, 5, 1'b1, 1'b1, 1'b1, 100, 20, 3);
        // shutter ending exactly at the limit: 516*4 - 20 - 10 = 2034
        run_line(2, 32, 2, 1, 0, 1'b0, 1'b0, 1'b1, 2034, 20, 0);

        // R10 refusals, one step past each limit
        try_refuse("R10 xfer_len 29", 1, 29, 2, 1, 0, 1'b0, 1'b0, 0, 0);
        try_refuse("R10 guard_len 0", 0, 30, 2, 1, 0, 1'b0, 1'b0, 0, 0);
        try_refuse("R10 half_len 1", 1, 30, 1, 1, 0, 1'b0, 1'b0, 0, 0);
        try_refuse("R10 rst_len equals half_len", 1, 30, 3, 3, 0, 1'b0, 1'b0, 0, 0);
        try_refuse("R10 rst_len 0", 1, 30, 3, 0, 0, 1'b0, 1'b0, 0, 0);
        try_refuse("R10 shut_len 19", 1, 30, 2, 1, 0, 1'b0, 1'b1, 10, 19);
        try_refuse("R10 shutter too late", 2, 32, 2, 1, 0, 1'b0, 1'b1, 2035, 20);
        check(overrun_cnt == 8'd3, "R11 refusals not counted as overrun", int'(overrun_cnt), 3);

        run_line(2, 40, 2, 1, 2, 1'b0, 1'b1, 1'b0, 0, 0, 1);

        // random short lines
        for (int r = 0; r < 8; r++) begin
            g    = 1 + int'($urandom % 4);
            x    = 30 + int'($urandom % 16);
            h    = 2 + int'($urandom % 4);
            rl   = 1 + int'($urandom % (h - 1));
            post = int'($urandom % 10);
            hold = 1'($urandom % 2);
            sh   = 1'($urandom % 2);
            len  = 20 + int'($urandom % 41);
            rd   = (4 + 512 + post) * 2 * h - len - 10;
            d    = int'($urandom % (rd + 1));
            run_line(g, x, h, rl, post, 1'b0, hold, sh, d, len, int'($urandom % 3));
        end
        report_and_end();
    end

endmodule